// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm Comparator

This block keeps a free-running 64-bit time-of-day count whose scale does not depend on the local tick rate. Bit 12 always means one microsecond. A prescaler divides the system clock down to a local tick, and every tick adds a fixed step to the count. A slow implementation therefore moves its upper bits at the same real-time rate as a fast one. Only its low-order bits stay coarser, and those bits hold zero below the real resolution.

Software uses a small register port. It can load the count, read the count, load and read a comparator, and clear the alarm. Two counter reads in a row always return different values, even on consecutive cycles. When the count has not moved since the previous read, the block returns one unit more than the last value it returned, and it takes that unit from the unused low bits. A delay is programmed by writing "current time plus delay" to the comparator. The alarm output rises once the count reaches or passes that value, and it stays high until software clears it.

Uniqueness holds for up to STEP counter reads within one tick period. The integrator chooses STEP and TICK_DIV together so that STEP is at least TICK_DIV.

Top module: `tod_alarm_timer`

## Requirements
- R1: After reset the count is 0, the comparator is all ones, alarm is low and rdValid is low.
- R2: A write to address 0 loads wrData into the count at that clock edge. A counter read in the next cycle returns exactly the loaded value.
- R3: The count advances by STEP once every TICK_DIV cycles. After a load at edge E, the first tick lands at edge E+TICK_DIV. After reset, the first tick lands at the TICK_DIV-th edge.
- R4: A read with rdEn high at an edge gives rdData with rdValid high in the following cycle. Address 0 returns the count, address 1 returns the comparator, and addresses 2 and 3 return 0.
- R5: When the count has not changed since the previous counter read, a counter read returns the previous returned value plus 1. Otherwise it returns the count.
- R6: The alarm is set one cycle after the count is unsigned greater than or equal to the comparator. It is sticky: loading a count below the comparator does not clear it.
- R7: A write to address 2, or any write to the comparator at address 1, clears the alarm at that edge. The alarm is then re-evaluated from the next cycle on.
- R8: The comparison is unsigned. A comparator of 0x8000_0000_0000_0000 is not reached by a small count.
- R9: The count wraps modulo 2^64.
- R10: When a counter write and a tick fall on the same edge, the written value wins and no step is added.
- R11: A counter write discards the read history. The first read after loading a value below the last returned value returns the loaded count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 count, 1 comparator, 2 alarm clear |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data, valid the cycle after rdEn |
| rdValid | output | 1 | Marks rdData as valid |
| alarm | output | 1 | Sticky alarm request |

## Verification
The bench builds the block with TICK_DIV = 4 and STEP = 256. A tick then arrives every four cycles, so a single burst of reads can cover a tick boundary. Such a burst exercises the +1 uniqueness rule and the fall-back to the real count when the tick arrives. The short period also lets the bench place a counter write on the exact edge of a tick. It also brings the wrap from 0xFFFF_FFFF_FFFF_FF00 to zero within one tick, and lets an alarm fire within a few cycles.

// File: rtl/todc_pkg.sv
package todc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR = 2'd2;

  typedef struct packed {
    logic ldCnt;
    logic ldCmp;
    logic clrAlarm;
    logic tick;
    logic rdCnt;
    logic rdCmp;
    logic rdAny;
  } todcStrobe_t;
endpackage

// File: rtl/todc_ctrl.sv
module todc_ctrl
  import todc_pkg::*;
#(
  parameter int TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output todcStrobe_t       strb
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tickRaw;

  // Register decode
  always_comb begin
    strb          = '0;
    strb.ldCnt    = wrEn && (addr == ADDR_COUNT);
    strb.ldCmp    = wrEn && (addr == ADDR_CMP);
    strb.clrAlarm = wrEn && (addr == ADDR_CLEAR);
    strb.rdCnt    = rdEn && (addr == ADDR_COUNT);
    strb.rdCmp    = rdEn && (addr == ADDR_CMP);
    strb.rdAny    = rdEn;
    strb.tick     = tickRaw;
  end

  // Tick prescaler: restarts on a counter load so the first tick follows
  // a full period after the new value.
  generate
    if (TICK_DIV > 1) begin : g_div
      logic [PRE_W-1:0] presc;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          presc <= '0;
        else if (strb.ldCnt || tickRaw)
          presc <= '0;
        else
          presc <= presc + 1'b1;
      end
      assign tickRaw = (presc == PRE_W'(TICK_DIV - 1));

      // R3: two ticks are never adjacent when dividing
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
        tickRaw |=> !tickRaw);
    end else begin : g_nodiv
      assign tickRaw = 1'b1;
    end
  endgenerate

  // R4: at most one write target is selected per cycle
  p_wr_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldCnt, strb.ldCmp, strb.clrAlarm}));
endmodule

// File: rtl/todc_dp.sv
module todc_dp
  import todc_pkg::*;
#(
  parameter int               CNT_W = 64,
  parameter logic [CNT_W-1:0] STEP  = CNT_W'(4096)
) (
  input  logic             clk,
  input  logic             rstN,
  input  todcStrobe_t      strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid,
  output logic             alarm
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0] lastRead;
  logic             haveLast;
  logic [CNT_W-1:0] retVal;
  logic             reached;

  // Time-of-day count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (strb.ldCnt)
      cnt <= wrData;
    else if (strb.tick)
      cnt <= cnt + STEP;
  end

  // Comparator register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cmpVal <= '1;
    else if (strb.ldCmp)
      cmpVal <= wrData;
  end

  assign reached = (cnt >= cmpVal);

  // Sticky alarm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      alarm <= 1'b0;
    else if (strb.ldCmp || strb.clrAlarm)
      alarm <= 1'b0;
    else if (reached)
      alarm <= 1'b1;
  end

  // Unique read value: bump past the last returned value while the
  // count has not moved since then.
  assign retVal = haveLast ? (lastRead + 1'b1) : cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastRead <= '0;
    end else if (strb.ldCnt || strb.tick) begin
      haveLast <= 1'b0;
    end else if (strb.rdCnt) begin
      haveLast <= 1'b1;
      lastRead <= retVal;
    end
  end

  // Read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdAny;
      if (strb.rdCnt)
        rdData <= retVal;
      else if (strb.rdCmp)
        rdData <= cmpVal;
      else if (strb.rdAny)
        rdData <= '0;
    end
  end

  // R3: a tick without load advances by exactly one step (modulo, R9)
  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.ldCnt) |=> (cnt == $past(cnt) + STEP));

  // R3: count holds between ticks
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.ldCnt) |=> $stable(cnt));

  // R2 / R10: a load wins over a coincident tick
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCnt |=> (cnt == $past(wrData)));

  // R5: a repeated read within a tick never repeats a value
  p_unique_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCnt && haveLast) |=> (rdData != $past(lastRead)));

  // R6: reaching the comparator raises the alarm next cycle
  p_alarm_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reached && !strb.ldCmp && !strb.clrAlarm) |=> alarm);

  // R6: the alarm is sticky
  p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (alarm && !strb.ldCmp && !strb.clrAlarm) |=> alarm);

  // R7: clearing takes effect at the edge
  p_alarm_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldCmp || strb.clrAlarm) |=> !alarm);
endmodule

// File: rtl/tod_alarm_timer.sv
module tod_alarm_timer
  import todc_pkg::*;
#(
  parameter int               CNT_W    = 64,
  parameter int               TICK_DIV = 50,
  parameter logic [CNT_W-1:0] STEP     = CNT_W'(4096)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             rdValid,
  output logic             alarm
);
  todcStrobe_t strb;

  todc_ctrl #(.TICK_DIV(TICK_DIV)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  todc_dp #(.CNT_W(CNT_W), .STEP(STEP)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .alarm   (alarm)
  );
endmodule

// File: tb/tod_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module tod_alarm_timer_tb_top;
  localparam int          D  = 4;
  localparam logic [63:0] ST = 64'd256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        rdValid;
  logic        alarm;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;

  // reference state
  logic [63:0] loadVal = '0;
  int          loadEdge = 0;
  bit          haveM = 1'b0;
  logic [63:0] lastM = '0;
  logic [63:0] lastBase = '0;
  logic [63:0] cmpM = '1;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeNo <= 0;
    else       edgeNo <= edgeNo + 1;
  end

  tod_alarm_timer #(.CNT_W(64), .TICK_DIV(D), .STEP(ST)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .alarm(alarm)
  );

  // count value seen by an operation sampled at edge n
  function automatic logic [63:0] cntAt(int n);
    return loadVal + 64'(unsigned'((n - loadEdge - 1) / D)) * ST;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic writeReg(logic [1:0] a, logic [63:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) begin
      loadVal = d; loadEdge = edgeNo; haveM = 1'b0;
    end else if (a == 2'd1) begin
      cmpM = d;
    end
  endtask

  task automatic readCnt(int k, string req);
    rdEn = 1'b1; addr = 2'd0;
    for (int i = 0; i < k; i++) begin
      logic [63:0] base, exp;
      @(negedge clk);
      if (i == k - 1) rdEn = 1'b0;
      base = cntAt(edgeNo);
      if (haveM && base == lastBase) exp = lastM + 1;
      else exp = base;
      haveM = 1'b1; lastBase = base; lastM = exp;
      check((haveM && exp != base) ? "R5" : req, rdData, exp);
      check("R4", 64'(rdValid), 64'd1);
    end
  endtask

  task automatic readReg(logic [1:0] a, logic [63:0] exp, string req);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(req, rdData, exp);
    check("R4", 64'(rdValid), 64'd1);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1", 64'(alarm), 64'd0);
    check("R1", 64'(rdValid), 64'd0);
    rstN = 1'b1;
    readCnt(1, "R1");
    readReg(2'd1, '1, "R1");
    idle(1);
    check("R4", 64'(rdValid), 64'd0);
  endtask

  task automatic testLoadTick();
    writeReg(2'd0, 64'h0123_4567_89AB_0000);
    readCnt(1, "R2");
    readCnt(10, "R3");
    idle(3);
    readCnt(2, "R3");
  endtask

  task automatic testWrap();
    writeReg(2'd0, 64'hFFFF_FFFF_FFFF_FF00);
    readCnt(6, "R9");
    check("R9", cntAt(edgeNo), 64'd0);
  endtask

  task automatic testReloadLower();
    writeReg(2'd0, 64'h0000_0000_0000_7000);
    readCnt(3, "R5");
    writeReg(2'd0, 64'h0000_0000_0000_1000);
    readCnt(1, "R11");
  endtask

  task automatic testWriteWins();
    while (((edgeNo + 1 - loadEdge) % D) != 0) @(negedge clk);
    writeReg(2'd0, 64'h0000_0000_0042_0000);
    readCnt(1, "R10");
    readCnt(D + 1, "R10");
  endtask

  task automatic testAlarm();
    writeReg(2'd0, 64'd1000);
    writeReg(2'd1, 64'd1000 + 3 * ST);
    check("R7", 64'(alarm), 64'd0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R6", 64'(alarm), 64'(cntAt(edgeNo) >= cmpM));
    end
    writeReg(2'd0, 64'd0);
    for (int i = 0; i < 5; i++) begin
      check("R6", 64'(alarm), 64'd1);
      @(negedge clk);
    end
    writeReg(2'd2, 64'd0);
    for (int i = 0; i < 10; i++) begin
      check("R7", 64'(alarm), 64'd0);
      @(negedge clk);
    end
    writeReg(2'd0, cmpM + 5);
    @(negedge clk);
    check("R6", 64'(alarm), 64'd1);
    writeReg(2'd2, 64'd0);
    check("R7", 64'(alarm), 64'd0);
    @(negedge clk);
    check("R7", 64'(alarm), 64'd1);
  endtask

  task automatic testUnsigned();
    writeReg(2'd0, 64'd5);
    writeReg(2'd1, 64'h8000_0000_0000_0000);
    for (int i = 0; i < 12; i++) begin
      check("R8", 64'(alarm), 64'd0);
      @(negedge clk);
    end
    readReg(2'd1, 64'h8000_0000_0000_0000, "R4");
    readReg(2'd2, 64'd0, "R4");
    readReg(2'd3, 64'd0, "R4");
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLoadTick();
    testWrap();
    testReloadLower();
    testWriteWins();
    testAlarm();
    testUnsigned();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule